// File: doc/BRIEF.md
# PS/2 Keyboard-Side Scan-Code Transmitter

This block plays the keyboard end of a PS/2 link. It watches a vector of key-held levels, one bit per key, and turns each change into scan-code bytes. A key going down produces its one-byte make code. A key coming up produces a two-byte break sequence: the prefix byte F0 followed by the key's make code. While the most recently pressed key stays down, its make code is re-sent on a typematic schedule. The first repeat comes a fixed delay after the press, and later repeats follow at a fixed period.

Each byte goes out as an 11-bit serial frame. The block generates the PS/2 clock itself by counting system-clock cycles. Both lines are open-drain: a port high means "pull the line low" and a port low means "release it". A small FIFO sits between the event scanner and the serializer. When the FIFO is full, the scanner stalls and holds the unprocessed key change. Bytes are therefore never lost or reordered, and the two bytes of a break sequence always leave back to back.

Key changes seen in the same clock cycle are handled one per cycle, lowest key index first. There is no host-to-device traffic and no clock-inhibit handling.

Top module: `ps2_kbd_tx`

## Requirements
- R1: Every byte is sent as one frame of 11 bits, in this order: a start bit of 0, the eight data bits least-significant first, a parity bit chosen so that the data bits plus parity hold an odd number of ones, and a stop bit of 1.
- R2: Each bit holds the clock line released for HALF_CYC cycles, then pulled low for HALF_CYC cycles. Falling edges within a frame are therefore 2*HALF_CYC cycles apart. The data line never changes while the clock line is pulled low.
- R3: Both lines are only ever pulled low or released. While `busy` is 0, both drive ports are 0 (lines released).
- R4: A key whose held bit goes from 0 to 1 causes its make code to be sent exactly once. Default codes by key index 0..3 are 1C, 12, 1B, 1D.
- R5: A key whose held bit goes from 1 to 0 causes F0 and then that key's make code to be sent, with no other byte between them.
- R6: While the most recently pressed key stays held, its make code is resent DELAY_CYC cycles after the press and then every REPEAT_CYC cycles.
- R7: Pressing another key moves the repeat to that key and restarts the delay. Releasing a key that is not the most recent one leaves the repeat running. Releasing the most recent key stops all repeats.
- R8: Overlapping key activity produces interleaved sequences in event order. For example: press key 1, press key 0, release key 0, release key 1 gives 12 1C F0 1C F0 12.
- R9: `busy` is 1 whenever the clock line is pulled low. It stays 1 from the first start bit of a queued sequence until the last stop bit has finished.
- R10: The FIFO never overflows. Key changes in the same cycle are served lowest index first, and the scanner stalls while the FIFO is full, so no byte is lost.
- R11: After reset, both lines are released, `busy` is 0, and no byte is sent while all keys stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_held | input | NKEYS | Level per key, 1 while the key is down |
| ps2_clk_low | output | 1 | 1 pulls the PS/2 clock line low, 0 releases it |
| ps2_dat_low | output | 1 | 1 pulls the PS/2 data line low, 0 releases it |
| busy | output | 1 | A byte sequence is queued or on the wire |

## Verification
A receiver model in the bench decodes the lines, checking every frame's start, parity and stop bits and the spacing of its falling edges. The key patterns are:
- Every key pressed and released on its own, which tells each code-table entry apart.
- A long hold, whose number of repeats is worked out from the delay and period.
- The overlapping two-key example, which confirms the interleaved order.
- A press-over-press pattern, which separates "repeat follows the newest key" from "repeat follows the first key".
- All keys changing in a single cycle, which fills the FIFO and shows that the stalled scanner keeps index order and keeps each break pair together.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t BREAK_PREFIX = 8'hF0;
  localparam int unsigned FRAME_BITS = 11;
  typedef enum logic [1:0] {TX_IDLE, TX_HIGH, TX_LOW, TX_GAP} tx_state_e;
endpackage

// File: rtl/kbd_event_scan.sv
module kbd_event_scan
  import kbd_pkg::*;
#(
  parameter int unsigned NKEYS = 4,
  parameter logic [NKEYS*8-1:0] KEY_CODES = 32'h1D1B121C,
  parameter int unsigned DELAY_CYC = 25_000_000,
  parameter int unsigned REPEAT_CYC = 5_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NKEYS-1:0] key_held,
  input  logic             fifo_full,
  output logic             push,
  output byte_t            push_byte,
  output logic             pend
);
  localparam int unsigned KW = (NKEYS > 1) ? $clog2(NKEYS) : 1;
  localparam int unsigned TMAX = (DELAY_CYC > REPEAT_CYC) ? DELAY_CYC : REPEAT_CYC;
  localparam int unsigned TW = $clog2(TMAX + 1);

  logic [NKEYS-1:0] prev_q, chg;
  logic [KW-1:0]    sel, last_q;
  logic             found, rep_on_q, pend_q, do_ev, do_rep;
  logic [TW-1:0]    timer_q;
  byte_t            pend_code_q, sel_code, last_code;

  for (genvar g = 0; g < NKEYS; g++) begin : g_chg
    assign chg[g] = key_held[g] ^ prev_q[g];
  end

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NKEYS; i++) begin
      if (chg[i] && !found) begin
        found = 1'b1;
        sel   = KW'(i);
      end
    end
  end

  assign sel_code  = KEY_CODES[int'(sel)*8 +: 8];
  assign last_code = KEY_CODES[int'(last_q)*8 +: 8];

  always_comb begin
    push      = 1'b0;
    push_byte = '0;
    do_ev     = 1'b0;
    do_rep    = 1'b0;
    if (!fifo_full) begin
      if (pend_q) begin
        push      = 1'b1;
        push_byte = pend_code_q;
      end else if (found) begin
        push      = 1'b1;
        do_ev     = 1'b1;
        push_byte = key_held[sel] ? sel_code : BREAK_PREFIX;
      end else if (rep_on_q && timer_q == '0) begin
        push      = 1'b1;
        do_rep    = 1'b1;
        push_byte = last_code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q      <= '0;
      last_q      <= '0;
      rep_on_q    <= 1'b0;
      pend_q      <= 1'b0;
      pend_code_q <= '0;
      timer_q     <= '0;
    end else begin
      if (rep_on_q && timer_q != '0) timer_q <= timer_q - 1'b1;
      if (pend_q && !fifo_full) pend_q <= 1'b0;
      if (do_ev) begin
        prev_q[sel] <= key_held[sel];
        if (key_held[sel]) begin
          last_q   <= sel;
          rep_on_q <= 1'b1;
          timer_q  <= TW'(DELAY_CYC - 1);
        end else begin
          pend_q      <= 1'b1;
          pend_code_q <= sel_code;
          if (last_q == sel) rep_on_q <= 1'b0;
        end
      end else if (do_rep) begin
        timer_q <= TW'(REPEAT_CYC - 1);
      end
    end
  end

  assign pend = pend_q;

  // R5: a break prefix is always followed by its code before anything else
  assert_break_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (push && !pend_q && push_byte == BREAK_PREFIX) |=> (pend_q && !do_ev && !do_rep));
endmodule

// File: rtl/kbd_byte_fifo.sv
module kbd_byte_fifo
  import kbd_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  byte_t wr_data,
  input  logic  rd_en,
  output byte_t rd_data,
  output logic  full,
  output logic  empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  byte_t         mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign rd_data = mem[rp_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) begin
        mem[wp_q] <= wr_data;
        wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (rd_en) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(wr_en) - (AW+1)'(rd_en);
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
endmodule

// File: rtl/kbd_frame_tx.sv
module kbd_frame_tx
  import kbd_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  byte_valid,
  input  byte_t byte_data,
  output logic  byte_ready,
  output logic  clk_low,
  output logic  dat_low,
  output logic  active
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);

  tx_state_e st_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [3:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic          clk_low_q, dat_low_q;

  assign byte_ready = (st_q == TX_IDLE);
  assign active     = (st_q != TX_IDLE);
  assign clk_low    = clk_low_q;
  assign dat_low    = dat_low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= TX_IDLE;
      sh_q      <= '1;
      bit_q     <= '0;
      cnt_q     <= '0;
      clk_low_q <= 1'b0;
      dat_low_q <= 1'b0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (byte_valid) begin
          sh_q      <= {1'b1, ~^byte_data, byte_data, 1'b0};
          bit_q     <= '0;
          cnt_q     <= CW'(HALF_CYC - 1);
          dat_low_q <= 1'b1;
          st_q      <= TX_HIGH;
        end
        TX_HIGH: if (cnt_q == '0) begin
          clk_low_q <= 1'b1;
          cnt_q     <= CW'(HALF_CYC - 1);
          st_q      <= TX_LOW;
        end else cnt_q <= cnt_q - 1'b1;
        TX_LOW: if (cnt_q == '0) begin
          clk_low_q <= 1'b0;
          cnt_q     <= CW'(HALF_CYC - 1);
          if (bit_q == 4'(FRAME_BITS - 1)) begin
            dat_low_q <= 1'b0;
            st_q      <= TX_GAP;
          end else begin
            bit_q     <= bit_q + 1'b1;
            sh_q      <= {1'b1, sh_q[FRAME_BITS-1:1]};
            dat_low_q <= ~sh_q[1];
            st_q      <= TX_HIGH;
          end
        end else cnt_q <= cnt_q - 1'b1;
        TX_GAP: if (cnt_q == '0) st_q <= TX_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assert_dat_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (clk_low_q && $past(clk_low_q)) |-> $stable(dat_low_q));
  assert_clk_low_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_low_q) |=> clk_low_q || (HALF_CYC == 1));
endmodule

// File: rtl/ps2_kbd_tx.sv
module ps2_kbd_tx
  import kbd_pkg::*;
#(
  parameter int unsigned NKEYS = 4,
  parameter logic [NKEYS*8-1:0] KEY_CODES = 32'h1D1B121C,
  parameter int unsigned HALF_CYC = 2000,
  parameter int unsigned DELAY_CYC = 25_000_000,
  parameter int unsigned REPEAT_CYC = 5_000_000,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NKEYS-1:0] key_held,
  output logic             ps2_clk_low,
  output logic             ps2_dat_low,
  output logic             busy
);
  logic  push, pend, full, empty, pop, tx_active;
  byte_t push_byte, head;

  kbd_event_scan #(
    .NKEYS(NKEYS), .KEY_CODES(KEY_CODES),
    .DELAY_CYC(DELAY_CYC), .REPEAT_CYC(REPEAT_CYC)
  ) u_scan (
    .clk(clk), .rst(rst), .key_held(key_held), .fifo_full(full),
    .push(push), .push_byte(push_byte), .pend(pend)
  );

  kbd_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(push_byte),
    .rd_en(pop), .rd_data(head), .full(full), .empty(empty)
  );

  logic tx_ready;
  assign pop = tx_ready && !empty;

  kbd_frame_tx #(.HALF_CYC(HALF_CYC)) u_tx (
    .clk(clk), .rst(rst), .byte_valid(!empty), .byte_data(head),
    .byte_ready(tx_ready), .clk_low(ps2_clk_low), .dat_low(ps2_dat_low),
    .active(tx_active)
  );

  assign busy = tx_active || !empty || pend;

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ps2_clk_low && !ps2_dat_low));
  assert_clk_busy_R9: assert property (@(posedge clk) disable iff (rst)
    ps2_clk_low |-> busy);
endmodule

// File: tb/tb_ps2_kbd_tx.sv
module tb_ps2_kbd_tx;
  localparam int NK = 4;
  localparam int H = 4;
  localparam int DLY = 600;
  localparam int REP = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NK-1:0] key_held = '0;
  logic cl, dl, busy;

  always #10 clk = ~clk;

  ps2_kbd_tx #(.NKEYS(NK), .KEY_CODES(32'h1D1B121C), .HALF_CYC(H),
    .DELAY_CYC(DLY), .REPEAT_CYC(REP), .FIFO_DEPTH(4)) dut (
    .clk(clk), .rst(rst), .key_held(key_held),
    .ps2_clk_low(cl), .ps2_dat_low(dl), .busy(busy));

  int checks = 0, fails = 0;
  logic [7:0] rxq [0:63];
  int rx_n = 0;
  logic [7:0] expq [0:63];
  int exp_n = 0;
  logic [7:0] code_of [0:3] = '{8'h1C, 8'h12, 8'h1B, 8'h1D};

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // receiver model
  logic pcl = 1'b0, pdl = 1'b0;
  int nbits = 0, since_fall = 0;
  logic [10:0] fr;
  always @(negedge clk) begin
    if (!rst) begin
      since_fall++;
      if (cl && pcl && dl != pdl) chk("R2 data moved under low clock", 1'b0, dl, pdl);
      if (cl && !busy) chk("R9 busy low while clock low", 1'b0, busy, 1);
      if (cl && !pcl) begin
        if (nbits > 0) chk("R2 falling edge spacing", since_fall == 2*H, since_fall, 2*H);
        since_fall = 0;
        fr[nbits] = ~dl;
        nbits++;
        if (nbits == 11) begin
          nbits = 0;
          chk("R1 frame start/parity/stop",
              fr[0] == 1'b0 && fr[10] == 1'b1 && (^fr[9:1]) == 1'b1, fr, 0);
          rxq[rx_n] = fr[8:1];
          rx_n++;
        end
      end
    end
    pcl = cl;
    pdl = dl;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic add(input logic [7:0] b);
    expq[exp_n] = b;
    exp_n++;
  endtask

  task automatic wait_idle();
    cyc(5);
    while (busy) @(negedge clk);
    cyc(10);
    chk("R3 lines released when idle", !cl && !dl, {cl, dl}, 0);
  endtask

  task automatic compare(input string req);
    chk({req, " byte count"}, rx_n == exp_n, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      chk({req, " byte"}, rxq[i] == expq[i], rxq[i], expq[i]);
    rx_n = 0;
    exp_n = 0;
  endtask

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(50);
    // R11 reset state and silence
    chk("R11 busy after reset", busy == 1'b0, busy, 0);
    chk("R11 lines after reset", !cl && !dl, {cl, dl}, 0);
    chk("R11 no bytes when idle", rx_n == 0, rx_n, 0);

    // R4 R5: each key alone
    for (int k = 0; k < NK; k++) begin
      key_held[k] = 1'b1; cyc(300);
      key_held[k] = 1'b0; wait_idle();
      add(code_of[k]); add(8'hF0); add(code_of[k]);
      compare("R4 R5 single key");
    end

    // R6: long hold of key 0, repeats at 600,800,1000,1200
    key_held[0] = 1'b1; cyc(1250);
    key_held[0] = 1'b0; wait_idle();
    for (int i = 0; i < 5; i++) add(8'h1C);
    add(8'hF0); add(8'h1C);
    compare("R6 typematic");

    // R8: overlapping keys
    key_held[1] = 1'b1; cyc(100);
    key_held[0] = 1'b1; cyc(100);
    key_held[0] = 1'b0; cyc(100);
    key_held[1] = 1'b0; wait_idle();
    add(8'h12); add(8'h1C); add(8'hF0); add(8'h1C); add(8'hF0); add(8'h12);
    compare("R8 interleave");

    // R7: repeat retargets to newest key, survives release of older key
    key_held[2] = 1'b1; cyc(400);
    key_held[3] = 1'b1; cyc(500);
    key_held[2] = 1'b0; cyc(200);
    key_held[3] = 1'b0; wait_idle();
    add(8'h1B); add(8'h1D); add(8'hF0); add(8'h1B); add(8'h1D); add(8'hF0); add(8'h1D);
    compare("R7 retarget");

    // R10: all keys in one cycle, FIFO fills
    key_held = '1; cyc(300);
    key_held = '0; wait_idle();
    for (int k = 0; k < NK; k++) add(code_of[k]);
    for (int k = 0; k < NK; k++) begin add(8'hF0); add(code_of[k]); end
    compare("R10 same-cycle order");
    chk("R9 busy clear at end", busy == 1'b0, busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule